// File: doc/BRIEF.md
# Bit-Addressable I/O Register Space

This block is the I/O register space that sits beside a small 8-bit processor core. The core reaches every register through two address views. The port view uses a 6-bit address from 0x00 to 0x3F for register-transfer instructions. The memory view places the same registers in the data-memory map, shifted up by a fixed offset. A second request channel carries single-bit operations from the core. These are set, clear, skip-if-set and skip-if-clear, and they are accepted only in the lower 32 locations. Set and clear are done by read-modify-write of the whole register, so any write-one-to-clear flag that reads as set is cleared as a side effect.

The space holds a few plain data registers that stand in for peripherals, one peripheral event-flag register with write-one-to-clear bits, and a processor status byte at the top address. The status byte carries the global interrupt enable. This enable gates the interrupt request that reaches the core, is dropped by hardware on interrupt entry and is raised again by a return strobe. The status byte also carries a bit-copy cell that the core loads and stores through dedicated strobes. All other addresses are reserved: they read as zero and ignore writes.

Top module: `ioreg_space`

## Requirements
- R1: A port-view access (`acc_is_mem`=0) hits addresses 0x00–0x3F. A memory-view access (`acc_is_mem`=1) hits 0x20–0x5F and reaches the register at its address minus 0x20. Any other address leaves `acc_hit` low, reads 0 and writes nothing. Read data is combinational.
- R2: Data registers sit at port addresses 0 to NUM_GP-1 and at HI_ADDR, and all are fully read/write. Every address not given a function reads 0 and ignores writes.
- R3: A bit operation with `bop_kind` 0 (set) or 1 (clear) at a port address below 0x20 changes the selected bit of a data register and leaves the other bits as they were. The result is readable after the next clock edge.
- R4: A bit operation at port address 0x20 or above raises `bop_illegal` in the same cycle, changes no register and holds `bop_skip` low.
- R5: A bit operation with `bop_kind` 2 (skip if set) or 3 (skip if clear) drives `bop_skip` in the same cycle from the addressed bit and changes no register.
- R6: The flag register at FLAG_ADDR holds FLAG_W flags. A `flag_set` pulse sets a flag. Writing a one to a flag clears it, and writing a zero leaves it as it is. Bits at FLAG_W and above read as 0.
- R7: A bit set or clear aimed at the flag register writes back the whole byte. A set therefore clears every flag that was set. A clear clears every set flag except the addressed one.
- R8: When a `flag_set` pulse and a clearing write reach the same flag in the same cycle, the flag ends set.
- R9: The status byte is at port address 0x3F. From bit 7 down it is I (interrupt enable), T (bit copy), H, S, V, N, Z, C. It resets to 0, is fully read/write and is mirrored on `sreg_out`.
- R10: `irq_out` is high only while `irq_req` is high and I is 1.
- R11: `irq_take` clears I after the clock edge, and `reti` sets it. `irq_take` wins over both `reti` and a software write in the same cycle.
- R12: A `bst_we` strobe stores `bst_val` into T, and this wins over a software write in the same cycle. `t_bit` always shows T for bit loads.
- R13: When a legal bit set or clear and a plain write happen in the same cycle, the bit operation is performed and the plain write is dropped.
- R14: After a synchronous active-low reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Byte access request |
| acc_is_mem | input | 1 | 1: memory-view address, 0: port-view address |
| acc_addr | input | 7 | Access address |
| acc_we | input | 1 | Write enable for the access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational) |
| acc_hit | output | 1 | Access falls inside the space |
| bop_valid | input | 1 | Bit operation request |
| bop_kind | input | 2 | 0 set, 1 clear, 2 skip-if-set, 3 skip-if-clear |
| bop_addr | input | 6 | Port-view address of the bit operation |
| bop_bit | input | 3 | Bit index |
| bop_skip | output | 1 | Skip condition of a test (combinational) |
| bop_illegal | output | 1 | Bit operation outside 0x00–0x1F |
| flag_set | input | FLAG_W | Peripheral flag set pulses |
| irq_req | input | 1 | Combined peripheral interrupt request |
| irq_take | input | 1 | Interrupt entry strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| bst_we | input | 1 | Bit-store strobe into T |
| bst_val | input | 1 | Value stored into T |
| t_bit | output | 1 | Current T for bit loads |
| irq_out | output | 1 | Gated interrupt request to the core |
| sreg_out | output | 8 | Status byte |

## Verification
The bench uses the default parameters: four low data registers at 0x00–0x03, a six-bit flag register at 0x08 and a high data register at 0x30. These values place a data register and the flag register inside the bit-operable range, while the high register and the status byte lie outside it. The bench can therefore test the read-modify-write side effect on live flags, the rejection of bit operations above 0x1F on a real register, and the reserved gaps between these registers. Flag bits 6 and 7 lie above FLAG_W, so the bench can also check that reserved bits read zero.

// File: rtl/ioreg_pkg.sv
// Package: shared constants for the bit-addressable I/O register space.
// Assumes an 8-bit data path and a 64-entry port-view address space.
package ioreg_pkg;
    localparam int DW        = 8;
    localparam int IO_AW     = 6;
    localparam int MEM_AW    = 7;
    localparam int IO_DEPTH  = 1 << IO_AW;
    localparam int BIT_SPAN  = 32;           // bit operations allowed below this
    localparam int BIT_IW    = $clog2(DW);

    localparam logic [IO_AW-1:0] SREG_ADDR = 6'h3F;

    // status byte bit positions (order is architectural)
    localparam int SB_I = 7;
    localparam int SB_T = 6;

    typedef enum logic [1:0] {
        BOP_SET  = 2'd0,
        BOP_CLR  = 2'd1,
        BOP_SKS  = 2'd2,
        BOP_SKC  = 2'd3
    } bop_kind_e;
endpackage

// File: rtl/ioreg_view_map.sv
// Module: ioreg_view_map
// Translates a port-view or memory-view address into a port address plus hit.
// Assumes the memory window starts at MEM_OFS and spans IO_DEPTH bytes.
module ioreg_view_map
    import ioreg_pkg::*;
#(
    parameter int MEM_OFS = 32
) (
    input  logic              valid_i,
    input  logic              is_mem_i,
    input  logic [MEM_AW-1:0] addr_i,
    output logic [IO_AW-1:0]  port_o,
    output logic              hit_o
);
    localparam int MEM_TOP = MEM_OFS + IO_DEPTH;

    logic [MEM_AW-1:0] shifted;

    // Purpose: subtract the window offset and range-check the chosen view.
    always_comb begin
        shifted = addr_i - MEM_AW'(MEM_OFS);
        if (is_mem_i) begin
            port_o = shifted[IO_AW-1:0];
            hit_o  = valid_i && (int'(addr_i) >= MEM_OFS) && (int'(addr_i) < MEM_TOP);
        end else begin
            port_o = addr_i[IO_AW-1:0];
            hit_o  = valid_i && (int'(addr_i) < IO_DEPTH);
        end
    end
endmodule

// File: rtl/ioreg_sel_dec.sv
// Module: ioreg_sel_dec
// One-hot register select from a port address; used for byte and bit paths.
// Assumes all register addresses given by parameters are distinct.
module ioreg_sel_dec
    import ioreg_pkg::*;
#(
    parameter int NUM_GP    = 4,
    parameter int FLAG_ADDR = 8,
    parameter int HI_ADDR   = 48
) (
    input  logic              en_i,
    input  logic [IO_AW-1:0]  addr_i,
    output logic [NUM_GP-1:0] gp_sel_o,
    output logic              hi_sel_o,
    output logic              flag_sel_o,
    output logic              sreg_sel_o
);
    // Purpose: one compare per low data register.
    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        assign gp_sel_o[g] = en_i && (addr_i == IO_AW'(g));
    end

    // Purpose: compares for the fixed-function registers.
    always_comb begin
        hi_sel_o   = en_i && (addr_i == IO_AW'(HI_ADDR));
        flag_sel_o = en_i && (addr_i == IO_AW'(FLAG_ADDR));
        sreg_sel_o = en_i && (addr_i == SREG_ADDR);
    end
endmodule

// File: rtl/ioreg_flag_bank.sv
// Module: ioreg_flag_bank
// Peripheral event flags: set by pulses, cleared by writing ones.
// Assumes a set pulse in the same cycle as a clear must leave the flag set.
module ioreg_flag_bank #(
    parameter int FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [FLAG_W-1:0] wdata_i,
    input  logic [FLAG_W-1:0] set_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] clr_mask;

    // Purpose: ones in the written data become the clear mask.
    always_comb clr_mask = wr_i ? wdata_i : '0;

    // Purpose: flag storage, set dominating clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_mask) | set_i;
    end
endmodule

// File: rtl/ioreg_status.sv
// Module: ioreg_status
// Status byte with interrupt-enable and bit-copy hooks.
// Assumes priority for I: entry strobe > return strobe > software write,
// and for T: bit-store strobe > software write.
module ioreg_status
    import ioreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          irq_take_i,
    input  logic          reti_i,
    input  logic          bst_we_i,
    input  logic          bst_val_i,
    output logic [DW-1:0] sreg_o
);
    logic [DW-1:0] nxt;

    // Purpose: layer the update sources from lowest to highest priority.
    always_comb begin
        nxt = wr_i ? wdata_i : sreg_o;
        if (bst_we_i)   nxt[SB_T] = bst_val_i;
        if (reti_i)     nxt[SB_I] = 1'b1;
        if (irq_take_i) nxt[SB_I] = 1'b0;
    end

    // Purpose: status byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) sreg_o <= '0;
        else        sreg_o <= nxt;
    end
endmodule

// File: rtl/ioreg_space.sv
// Module: ioreg_space (top)
// I/O register space with port and memory views, bit operations in the low
// 32 addresses by read-modify-write, write-one-to-clear flags and status byte.
// Assumes FLAG_W <= 8, FLAG_ADDR and NUM_GP-1 below 0x20 for bit access,
// and at most one byte access and one bit operation per cycle.
module ioreg_space
    import ioreg_pkg::*;
#(
    parameter int NUM_GP    = 4,
    parameter int FLAG_ADDR = 8,
    parameter int FLAG_W    = 6,
    parameter int HI_ADDR   = 48,
    parameter int MEM_OFS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_mem,
    input  logic [6:0]        acc_addr,
    input  logic              acc_we,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              acc_hit,
    input  logic              bop_valid,
    input  logic [1:0]        bop_kind,
    input  logic [5:0]        bop_addr,
    input  logic [2:0]        bop_bit,
    output logic              bop_skip,
    output logic              bop_illegal,
    input  logic [FLAG_W-1:0] flag_set,
    input  logic              irq_req,
    input  logic              irq_take,
    input  logic              reti,
    input  logic              bst_we,
    input  logic              bst_val,
    output logic              t_bit,
    output logic              irq_out,
    output logic [7:0]        sreg_out
);
    logic [IO_AW-1:0]  acc_port;
    logic              bop_legal;
    logic [NUM_GP-1:0] a_gp, b_gp;
    logic              a_hi, a_flag, a_sreg;
    logic              b_hi, b_flag, b_sreg;
    logic [DW-1:0]     gp_q [NUM_GP];
    logic [DW-1:0]     hi_q;
    logic [FLAG_W-1:0] flag_val;
    logic [DW-1:0]     flag_byte;
    logic [DW-1:0]     sreg_q;
    logic [DW-1:0]     rd_b;
    logic [DW-1:0]     bit_mask;
    logic [DW-1:0]     bop_mod;
    logic              bop_wr;
    logic              acc_wr;
    logic [DW-1:0]     wr_data;
    logic [NUM_GP-1:0] gp_we;
    logic              hi_we, flag_we, sreg_we;
    logic [NUM_GP*DW-1:0] gp_flat;

    // Purpose: translate the byte-access address into the port view.
    ioreg_view_map #(.MEM_OFS(MEM_OFS)) u_view (
        .valid_i (acc_valid),
        .is_mem_i(acc_is_mem),
        .addr_i  (acc_addr),
        .port_o  (acc_port),
        .hit_o   (acc_hit)
    );

    // Purpose: bit operations are legal only in the lower 32 locations.
    always_comb begin
        bop_legal   = bop_valid && (int'(bop_addr) < BIT_SPAN);
        bop_illegal = bop_valid && !bop_legal;
    end

    // Purpose: register select for the byte access.
    ioreg_sel_dec #(.NUM_GP(NUM_GP), .FLAG_ADDR(FLAG_ADDR), .HI_ADDR(HI_ADDR)) u_dec_a (
        .en_i      (acc_hit),
        .addr_i    (acc_port),
        .gp_sel_o  (a_gp),
        .hi_sel_o  (a_hi),
        .flag_sel_o(a_flag),
        .sreg_sel_o(a_sreg)
    );

    // Purpose: register select for the bit operation.
    ioreg_sel_dec #(.NUM_GP(NUM_GP), .FLAG_ADDR(FLAG_ADDR), .HI_ADDR(HI_ADDR)) u_dec_b (
        .en_i      (bop_legal),
        .addr_i    (bop_addr),
        .gp_sel_o  (b_gp),
        .hi_sel_o  (b_hi),
        .flag_sel_o(b_flag),
        .sreg_sel_o(b_sreg)
    );

    // Purpose: flag register read value with reserved bits forced to zero.
    always_comb flag_byte = DW'(flag_val);

    // Purpose: read multiplexers for the byte path and the bit path.
    always_comb begin
        acc_rdata = '0;
        rd_b      = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            if (a_gp[i]) acc_rdata = acc_rdata | gp_q[i];
            if (b_gp[i]) rd_b      = rd_b | gp_q[i];
        end
        if (a_hi)   acc_rdata = acc_rdata | hi_q;
        if (a_flag) acc_rdata = acc_rdata | flag_byte;
        if (a_sreg) acc_rdata = acc_rdata | sreg_q;
        if (b_hi)   rd_b      = rd_b | hi_q;
        if (b_flag) rd_b      = rd_b | flag_byte;
        if (b_sreg) rd_b      = rd_b | sreg_q;
    end

    // Purpose: bit modify and skip evaluation on the bit-path read value.
    always_comb begin
        bit_mask = DW'(1) << bop_bit;
        bop_wr   = 1'b0;
        bop_skip = 1'b0;
        bop_mod  = rd_b;
        if (bop_legal) begin
            case (bop_kind)
                BOP_SET: begin bop_mod = rd_b | bit_mask;  bop_wr = 1'b1; end
                BOP_CLR: begin bop_mod = rd_b & ~bit_mask; bop_wr = 1'b1; end
                BOP_SKS: bop_skip = rd_b[bop_bit];
                default: bop_skip = !rd_b[bop_bit];
            endcase
        end
    end

    // Purpose: a bit write takes the write port; a plain write then drops.
    always_comb begin
        acc_wr  = acc_hit && acc_we && !bop_wr;
        wr_data = bop_wr ? bop_mod : acc_wdata;
        for (int i = 0; i < NUM_GP; i++)
            gp_we[i] = bop_wr ? b_gp[i] : (acc_wr && a_gp[i]);
        hi_we   = acc_wr && a_hi;  // not bit-reachable
        flag_we = bop_wr ? b_flag : (acc_wr && a_flag);
        sreg_we = acc_wr && a_sreg; // not bit-reachable
    end

    // Purpose: low data registers standing in for peripheral registers.
    for (genvar g = 0; g < NUM_GP; g++) begin : g_gpreg
        always_ff @(posedge clk) begin
            if (!rst_n)        gp_q[g] <= '0;
            else if (gp_we[g]) gp_q[g] <= wr_data;
        end
        assign gp_flat[g*DW +: DW] = gp_q[g];
    end

    // Purpose: high data register outside the bit-operable range.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_we) hi_q <= wr_data;
    end

    // Purpose: write-one-to-clear peripheral flags.
    ioreg_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (flag_we),
        .wdata_i(wr_data[FLAG_W-1:0]),
        .set_i  (flag_set),
        .flags_o(flag_val)
    );

    // Purpose: status byte with interrupt and bit-copy hooks.
    ioreg_status u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (sreg_we),
        .wdata_i   (wr_data),
        .irq_take_i(irq_take),
        .reti_i    (reti),
        .bst_we_i  (bst_we),
        .bst_val_i (bst_val),
        .sreg_o    (sreg_q)
    );

    // Purpose: core-facing status outputs.
    always_comb begin
        sreg_out = sreg_q;
        t_bit    = sreg_q[SB_T];
        irq_out  = irq_req && sreg_q[SB_I];
    end
endmodule

// File: rtl/ioreg_space_chk.sv
// Module: ioreg_space_chk
// Temporal checks on the I/O register space, bound to the top module.
// Assumes it observes the top's ports and its internal flag and data storage.
module ioreg_space_chk #(
    parameter int FLAG_W = 6,
    parameter int GPW    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_we,
    input logic              bop_valid,
    input logic [1:0]        bop_kind,
    input logic              bop_skip,
    input logic              bop_illegal,
    input logic [FLAG_W-1:0] flag_set,
    input logic [FLAG_W-1:0] flag_val,
    input logic [GPW-1:0]    gp_flat,
    input logic              irq_take,
    input logic              reti,
    input logic              bst_we,
    input logic              bst_val,
    input logic              irq_out,
    input logic [7:0]        sreg_out
);
    a_r4_illegal_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        bop_illegal |-> !bop_skip);

    a_r5_test_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bop_valid && bop_kind[1] && !(acc_valid && acc_we)) |=> $stable(gp_flat));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> ((flag_val & $past(flag_set)) == $past(flag_set)));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> sreg_out[7]);

    a_r11_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !sreg_out[7]);

    a_r11_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !irq_take) |=> sreg_out[7]);

    a_r12_bst_stores: assert property (@(posedge clk) disable iff (!rst_n)
        bst_we |=> (sreg_out[6] == $past(bst_val)));
endmodule

bind ioreg_space ioreg_space_chk #(.FLAG_W(FLAG_W), .GPW(NUM_GP*8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_we     (acc_we),
    .bop_valid  (bop_valid),
    .bop_kind   (bop_kind),
    .bop_skip   (bop_skip),
    .bop_illegal(bop_illegal),
    .flag_set   (flag_set),
    .flag_val   (flag_val),
    .gp_flat    (gp_flat),
    .irq_take   (irq_take),
    .reti       (reti),
    .bst_we     (bst_we),
    .bst_val    (bst_val),
    .irq_out    (irq_out),
    .sreg_out   (sreg_out)
);

// File: tb/ioreg_space_tb.sv
// Directed bench for ioreg_space, one task per scenario, default parameters.
module ioreg_space_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid, acc_is_mem, acc_we;
    logic [6:0] acc_addr;
    logic [7:0] acc_wdata, acc_rdata;
    logic       acc_hit;
    logic       bop_valid;
    logic [1:0] bop_kind;
    logic [5:0] bop_addr;
    logic [2:0] bop_bit;
    logic       bop_skip, bop_illegal;
    logic [5:0] flag_set;
    logic       irq_req, irq_take, reti, bst_we, bst_val;
    logic       t_bit, irq_out;
    logic [7:0] sreg_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    ioreg_space dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_is_mem(acc_is_mem), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_hit(acc_hit),
        .bop_valid(bop_valid), .bop_kind(bop_kind), .bop_addr(bop_addr), .bop_bit(bop_bit),
        .bop_skip(bop_skip), .bop_illegal(bop_illegal),
        .flag_set(flag_set), .irq_req(irq_req), .irq_take(irq_take), .reti(reti),
        .bst_we(bst_we), .bst_val(bst_val), .t_bit(t_bit), .irq_out(irq_out),
        .sreg_out(sreg_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_is_mem = 0; acc_addr = '0; acc_we = 0; acc_wdata = '0;
        bop_valid = 0; bop_kind = '0; bop_addr = '0; bop_bit = '0;
        flag_set = '0; irq_take = 0; reti = 0; bst_we = 0; bst_val = 0;
    endtask

    // wait for the next rising edge, then move away from it
    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic wr(input bit mem, input logic [6:0] a, input logic [7:0] d);
        acc_valid = 1; acc_is_mem = mem; acc_addr = a; acc_we = 1; acc_wdata = d;
        step();
        idle();
    endtask

    task automatic rd(input bit mem, input logic [6:0] a, output logic [7:0] d);
        acc_valid = 1; acc_is_mem = mem; acc_addr = a; acc_we = 0;
        #1;
        d = acc_rdata;
        idle();
    endtask

    task automatic bop(input logic [1:0] k, input logic [5:0] a, input logic [2:0] b);
        bop_valid = 1; bop_kind = k; bop_addr = a; bop_bit = b;
        step();
        idle();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(0, 7'h01, d);  chk("R14 data reg after reset", d, 8'h00);
        rd(0, 7'h08, d);  chk("R14 flags after reset", d, 8'h00);
        chk("R14 R9 status after reset", sreg_out, 8'h00);
    endtask

    task automatic t_views();
        logic [7:0] d;
        wr(1, 7'h21, 8'h33);
        rd(0, 7'h01, d);  chk("R1 memory write seen at port 0x01", d, 8'h33);
        wr(0, 7'h30, 8'hA5);
        rd(1, 7'h50, d);  chk("R1 R2 port 0x30 seen at memory 0x50", d, 8'hA5);
        acc_valid = 1; acc_is_mem = 1; acc_addr = 7'h10; #1;
        chk("R1 memory 0x10 no hit", {7'b0, acc_hit}, 8'h00);
        acc_addr = 7'h60; #1;
        chk("R1 memory 0x60 no hit", {7'b0, acc_hit}, 8'h00);
        acc_is_mem = 0; acc_addr = 7'h40; #1;
        chk("R1 port 0x40 no hit", {7'b0, acc_hit}, 8'h00);
        idle();
        wr(1, 7'h10, 8'hEE);
        wr(0, 7'h40, 8'hEE);
        rd(0, 7'h10, d);  chk("R1 out-of-window write ignored", d, 8'h00);
        rd(0, 7'h00, d);  chk("R1 out-of-window write ignored (0x00)", d, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(0, 7'h05, 8'hFF);
        rd(0, 7'h05, d);  chk("R2 reserved reads zero", d, 8'h00);
        wr(0, 7'h03, 8'hC3);
        rd(0, 7'h03, d);  chk("R2 data reg 0x03 read/write", d, 8'hC3);
    endtask

    task automatic t_bitops();
        logic [7:0] d;
        wr(0, 7'h01, 8'h5A);
        bop(2'd0, 6'h01, 3'd0);
        rd(0, 7'h01, d);  chk("R3 bit set", d, 8'h5B);
        bop(2'd1, 6'h01, 3'd6);
        rd(0, 7'h01, d);  chk("R3 bit clear", d, 8'h1B);
    endtask

    task automatic t_illegal();
        logic [7:0] d;
        wr(0, 7'h30, 8'h00);
        bop_valid = 1; bop_kind = 2'd0; bop_addr = 6'h30; bop_bit = 3'd0; #1;
        chk("R4 illegal flagged", {7'b0, bop_illegal}, 8'h01);
        bop_kind = 2'd3; #1;
        chk("R4 illegal test no skip", {7'b0, bop_skip}, 8'h00);
        bop_kind = 2'd0;
        step();
        idle();
        rd(0, 7'h30, d);  chk("R4 illegal set ignored", d, 8'h00);
        bop(2'd1, 6'h3F, 3'd0);
        chk("R4 bit op on status ignored", sreg_out, 8'h00);
    endtask

    task automatic t_skip();
        logic [7:0] d;
        wr(0, 7'h02, 8'h04);
        bop_valid = 1; bop_kind = 2'd2; bop_addr = 6'h02; bop_bit = 3'd2; #1;
        chk("R5 skip-if-set on set bit", {7'b0, bop_skip}, 8'h01);
        bop_bit = 3'd1; #1;
        chk("R5 skip-if-set on clear bit", {7'b0, bop_skip}, 8'h00);
        bop_kind = 2'd3; #1;
        chk("R5 skip-if-clear on clear bit", {7'b0, bop_skip}, 8'h01);
        step();
        idle();
        rd(0, 7'h02, d);  chk("R5 test has no side effect", d, 8'h04);
    endtask

    task automatic t_flags();
        logic [7:0] d;
        flag_set = 6'h3F; step(); idle();
        rd(0, 7'h08, d);  chk("R6 all flags set, reserved bits zero", d, 8'h3F);
        wr(0, 7'h08, 8'h05);
        rd(0, 7'h08, d);  chk("R6 write ones clears only those", d, 8'h3A);
        wr(0, 7'h08, 8'h00);
        rd(0, 7'h08, d);  chk("R6 write zero no effect", d, 8'h3A);
        wr(0, 7'h08, 8'hFF);
        rd(0, 7'h08, d);  chk("R6 clear all", d, 8'h00);
    endtask

    task automatic t_flag_rmw();
        logic [7:0] d;
        flag_set = 6'h05; step(); idle();
        bop(2'd0, 6'h08, 3'd4);
        rd(0, 7'h08, d);  chk("R7 bit set clears all set flags", d, 8'h00);
        flag_set = 6'h0B; step(); idle();
        bop(2'd1, 6'h08, 3'd1);
        rd(0, 7'h08, d);  chk("R7 bit clear keeps only target flag", d, 8'h02);
        wr(0, 7'h08, 8'hFF);
    endtask

    task automatic t_flag_race();
        logic [7:0] d;
        flag_set = 6'h01; step(); idle();
        acc_valid = 1; acc_addr = 7'h08; acc_we = 1; acc_wdata = 8'h01; flag_set = 6'h01;
        step(); idle();
        rd(0, 7'h08, d);  chk("R8 set wins over clear", d, 8'h01);
        acc_valid = 1; acc_addr = 7'h08; acc_we = 1; acc_wdata = 8'h01; flag_set = 6'h04;
        step(); idle();
        rd(0, 7'h08, d);  chk("R8 clear other flag while setting", d, 8'h04);
        wr(0, 7'h08, 8'hFF);
    endtask

    task automatic t_sreg();
        logic [7:0] d;
        wr(0, 7'h3F, 8'h3C);
        chk("R9 status write", sreg_out, 8'h3C);
        rd(1, 7'h5F, d);  chk("R9 status at memory 0x5F", d, 8'h3C);
    endtask

    task automatic t_irq();
        wr(0, 7'h3F, 8'h80);
        irq_req = 1; #1;
        chk("R10 request passes with I set", {7'b0, irq_out}, 8'h01);
        acc_valid = 1; acc_addr = 7'h3F; acc_we = 1; acc_wdata = 8'hFF; irq_take = 1;
        step(); idle();
        chk("R11 take beats write", sreg_out, 8'h7F);
        chk("R10 request blocked with I clear", {7'b0, irq_out}, 8'h00);
        reti = 1; step(); idle();
        chk("R11 return sets I", sreg_out, 8'hFF);
        reti = 1; irq_take = 1; step(); idle();
        chk("R11 take beats return", sreg_out, 8'h7F);
        irq_req = 0;
    endtask

    task automatic t_bst();
        acc_valid = 1; acc_addr = 7'h3F; acc_we = 1; acc_wdata = 8'h00; bst_we = 1; bst_val = 1;
        step(); idle();
        chk("R12 bit store beats write", sreg_out, 8'h40);
        chk("R12 T output", {7'b0, t_bit}, 8'h01);
        bst_we = 1; bst_val = 0; step(); idle();
        chk("R12 bit store zero", {7'b0, t_bit}, 8'h00);
    endtask

    task automatic t_prio();
        logic [7:0] d;
        wr(0, 7'h00, 8'h00);
        wr(0, 7'h02, 8'h11);
        bop_valid = 1; bop_kind = 2'd0; bop_addr = 6'h00; bop_bit = 3'd3;
        acc_valid = 1; acc_addr = 7'h02; acc_we = 1; acc_wdata = 8'h77;
        step(); idle();
        rd(0, 7'h00, d);  chk("R13 bit op performed", d, 8'h08);
        rd(0, 7'h02, d);  chk("R13 plain write dropped", d, 8'h11);
    endtask

    initial begin
        idle();
        irq_req = 0;
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        t_reset();
        t_views();
        t_reserved();
        t_bitops();
        t_illegal();
        t_skip();
        t_flags();
        t_flag_rmw();
        t_flag_race();
        t_sreg();
        t_irq();
        t_bst();
        t_prio();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule